// File: doc/BRIEF.md
# Shared-Counter First-Crossing Result Capture

This block collects the digital results of a row of column converters that all share one free-running code counter. Each converter contributes one comparator bit that has already been latched on the clock. During the discharge phase of a conversion, the block watches every channel. The first clock on which a channel's comparator reads high freezes the shared count into that channel's result register. Any further highs from that channel in the same conversion are dropped.

A channel that never reads high during discharge is reported as over range. When discharge ends, all results and over-range flags move together into registered outputs, and a one-clock valid strobe marks the new set. The sequencer that steps the phases and the counter sits outside the block. It drives the phase code and the count, and the block only observes them.

Top module: `fcap_array`

## Requirements
- R1: On the first clock of a discharge phase on which a channel's comparator input is high, that channel's result is the value of `count_i` on that same clock.
- R2: After a channel has captured, further comparator highs from it in the same discharge phase do not change its reported result.
- R3: Comparator highs on clocks whose phase code is not discharge have no effect on any reported result or flag.
- R4: A channel with no comparator high during the whole discharge phase reports over range (its `ovf_o` bit is 1) with a result of all ones (63 at the default width). A channel that captured reports `ovf_o` bit 0.
- R5: On the first clock whose phase code is not discharge after one or more discharge clocks, the block registers the new results. `valid_o` is then high for exactly one cycle, and `res_o` and `ovf_o` change only together with that strobe.
- R6: Channels are independent. Channel i uses bits [i*CW +: CW] of `res_o` and bit i of `ovf_o`.
- R7: A synchronous active-high `rst` clears all results, over-range flags, per-channel capture state and `valid_o` to 0. A conversion interrupted by reset produces no strobe.
- R8: The phase code on `phase_i` is 2'b00 reset, 2'b01 charge, 2'b10 discharge and 2'b11 idle. Only 2'b10 is treated as discharge.
- R9: Capture state is cleared at the start of every discharge phase, so a capture made in one conversion does not carry into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | 2 | Phase code from the sequencer |
| count_i | input | CW | Shared counter value |
| cmp_i | input | NCH | Latched comparator bits, one per channel, synchronous to clk |
| res_o | output | NCH*CW | Registered per-channel results, channel i at [i*CW +: CW] |
| ovf_o | output | NCH | Registered per-channel over-range flags |
| valid_o | output | 1 | One-cycle strobe when a new result set is loaded |

## Verification
The bench builds the block with its defaults: eight channels and a six-bit count, with a 64-clock discharge phase that sweeps the full code range. These values make both ends of the scale reachable: a capture on code 0 at the first discharge clock, a capture on code 63 at the last, and the all-ones over-range result that can be confused with a genuine capture of 63. With eight channels, one conversion can mix first-clock, last-clock, mid-scale and over-range channels. The same setup also exercises the idle phase code and a reset that arrives in the middle of discharge.

// File: rtl/fcap_pkg.sv
package fcap_pkg;

  typedef enum logic [1:0] {
    PH_RST  = 2'b00,
    PH_CHG  = 2'b01,
    PH_DIS  = 2'b10,
    PH_IDLE = 2'b11
  } phase_e;

endpackage

// File: rtl/fcap_phase_track.sv
module fcap_phase_track
  import fcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] phase_i,
  output logic       dis_o,
  output logic       start_o,
  output logic       fin_o,
  output logic       valid_o
);

  logic dis_q;

  assign dis_o   = (phase_i == PH_DIS);
  assign start_o = dis_o & ~dis_q;
  assign fin_o   = ~dis_o & dis_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      dis_q   <= dis_o;
      valid_o <= fin_o;
    end
  end

endmodule

// File: rtl/fcap_channel.sv
module fcap_channel #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dis_i,
  input  logic          start_i,
  input  logic          fin_i,
  input  logic          cmp_i,
  input  logic [CW-1:0] count_i,
  output logic [CW-1:0] res_o,
  output logic          ovf_o
);

  logic          caught_q;
  logic [CW-1:0] hit_q;
  logic          take;

  // a new discharge phase ignores the previous caught flag
  assign take = dis_i & cmp_i & (start_i | ~caught_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      caught_q <= 1'b0;
      hit_q    <= '0;
    end else begin
      if (start_i) caught_q <= cmp_i;
      else if (take) caught_q <= 1'b1;
      if (take) hit_q <= count_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
      ovf_o <= 1'b0;
    end else if (fin_i) begin
      res_o <= caught_q ? hit_q : {CW{1'b1}};
      ovf_o <= ~caught_q;
    end
  end

endmodule

// File: rtl/fcap_array.sv
module fcap_array #(
  parameter int NCH = 8,
  parameter int CW  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        phase_i,
  input  logic [CW-1:0]     count_i,
  input  logic [NCH-1:0]    cmp_i,
  output logic [NCH*CW-1:0] res_o,
  output logic [NCH-1:0]    ovf_o,
  output logic              valid_o
);

  logic dis, start, fin;

  fcap_phase_track u_phase (
    .clk     (clk),
    .rst     (rst),
    .phase_i (phase_i),
    .dis_o   (dis),
    .start_o (start),
    .fin_o   (fin),
    .valid_o (valid_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    fcap_channel #(.CW(CW)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .dis_i   (dis),
      .start_i (start),
      .fin_i   (fin),
      .cmp_i   (cmp_i[i]),
      .count_i (count_i),
      .res_o   (res_o[i*CW +: CW]),
      .ovf_o   (ovf_o[i])
    );
  end

endmodule

// File: rtl/fcap_array_chk.sv
module fcap_array_chk #(
  parameter int NCH = 8,
  parameter int CW  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        phase_i,
  input logic [NCH*CW-1:0] res_o,
  input logic [NCH-1:0]    ovf_o,
  input logic              valid_o
);

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R5

  AST_VALID_AFTER_DIS: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ($past(phase_i, 2) == 2'b10 && $past(phase_i, 1) != 2'b10)); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(res_o) && $stable(ovf_o))); // R5

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!valid_o && ovf_o == '0 && res_o == '0)); // R7

  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      ovf_o[i] |-> res_o[i*CW +: CW] == {CW{1'b1}}); // R4
  end

endmodule

bind fcap_array fcap_array_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .phase_i (phase_i),
  .res_o   (res_o),
  .ovf_o   (ovf_o),
  .valid_o (valid_o)
);

// File: tb/fcap_array_bench.sv
module fcap_array_bench;

  localparam int NCH = 8;
  localparam int CW  = 6;
  localparam int NCODE = 1 << CW;
  localparam time TCLK = 10ns;

  typedef struct packed {
    logic [NCH*CW-1:0] res;
    logic [NCH-1:0]    ovf;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        phase_i = 2'b00;
  logic [CW-1:0]     count_i = '0;
  logic [NCH-1:0]    cmp_i = '0;
  logic [NCH*CW-1:0] res_o;
  logic [NCH-1:0]    ovf_o;
  logic              valid_o;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int popped = 0;
  int first_at [NCH];
  exp_t q[$];

  always #(TCLK/2) clk = ~clk;

  fcap_array #(.NCH(NCH), .CW(CW)) u_fcap_array (
    .clk(clk), .rst(rst), .phase_i(phase_i), .count_i(count_i),
    .cmp_i(cmp_i), .res_o(res_o), .ovf_o(ovf_o), .valid_o(valid_o)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive a non-discharge phase with random comparator noise (R3)
  task automatic idle_phase(input logic [1:0] code, input int n, input bit all_high);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      phase_i = code;
      count_i = CW'(k);
      cmp_i   = all_high ? '1 : NCH'($urandom);
    end
  endtask

  // one conversion; first_at[i] < 0 means no crossing
  task automatic conversion(input logic [1:0] pre_code, input bit noisy_pre);
    exp_t e;
    idle_phase(pre_code, 4, noisy_pre);
    idle_phase(2'b01, 4, noisy_pre);
    for (int c = 0; c < NCODE; c++) begin
      @(negedge clk);
      phase_i = 2'b10;
      count_i = CW'(c);
      for (int i = 0; i < NCH; i++) begin
        if (first_at[i] < 0 || c < first_at[i]) cmp_i[i] = 1'b0;
        else if (c == first_at[i]) cmp_i[i] = 1'b1;
        else cmp_i[i] = 1'($urandom); // R2 repeat highs
      end
    end
    for (int i = 0; i < NCH; i++) begin
      e.res[i*CW +: CW] = (first_at[i] < 0) ? {CW{1'b1}} : CW'(first_at[i]);
      e.ovf[i] = (first_at[i] < 0);
    end
    q.push_back(e);
    pushed++;
    @(negedge clk);
    phase_i = 2'b00;
    cmp_i = '1; // R3 highs outside discharge
  endtask

  // monitor / scoreboard
  initial begin
    logic [NCH*CW-1:0] prev_res = '0;
    logic [NCH-1:0]    prev_ovf = '0;
    logic              prev_valid = 1'b0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (prev_valid) check(!valid_o, "R5 strobe width", 64'(valid_o), 64'd0);
        if (valid_o) begin
          if (q.size() == 0) check(1'b0, "R5 unexpected strobe", 64'd1, 64'd0);
          else begin
            e = q.pop_front();
            popped++;
            for (int i = 0; i < NCH; i++) begin
              check(res_o[i*CW +: CW] == e.res[i*CW +: CW], "R1/R2/R4/R6 result",
                    64'(res_o[i*CW +: CW]), 64'(e.res[i*CW +: CW]));
              check(ovf_o[i] == e.ovf[i], "R4/R9 overflow flag", 64'(ovf_o[i]), 64'(e.ovf[i]));
            end
          end
        end else if (res_o != prev_res || ovf_o != prev_ovf) begin
          check(1'b0, "R5 outputs changed without strobe", 64'(res_o), 64'(prev_res));
        end
      end
      prev_res = res_o;
      prev_ovf = ovf_o;
      prev_valid = valid_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    check(valid_o == 1'b0, "R7 valid after reset", 64'(valid_o), 64'd0);
    check(res_o == '0, "R7 results after reset", 64'(res_o), 64'd0);
    check(ovf_o == '0, "R7 flags after reset", 64'(ovf_o), 64'd0);
    rst = 1'b0;

    // R1 R2 R4 R6: mixed channels, both code ends
    first_at = '{0, 63, 5, -1, 10, 31, -1, 1};
    conversion(2'b00, 1'b1);

    // R3 R9: previous captures must not carry over
    first_at = '{-1, -1, -1, -1, -1, -1, -1, -1};
    conversion(2'b00, 1'b1);

    // R8: idle code with all comparators high is not discharge
    for (int i = 0; i < NCH; i++) first_at[i] = i * 9;
    conversion(2'b11, 1'b1);
    idle_phase(2'b11, 6, 1'b1);

    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < NCH; i++) first_at[i] = int'($urandom_range(0, NCODE)) - 1;
      conversion(2'b00, 1'b1);
    end

    // R7: reset in the middle of discharge gives no strobe
    idle_phase(2'b01, 3, 1'b0);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      phase_i = 2'b10;
      count_i = CW'(c);
      cmp_i = '1;
    end
    @(negedge clk);
    rst = 1'b1;
    phase_i = 2'b00;
    @(negedge clk);
    @(negedge clk);
    check(res_o == '0 && ovf_o == '0, "R7 mid-conversion reset", 64'(res_o), 64'd0);
    rst = 1'b0;
    idle_phase(2'b00, 4, 1'b0);
    check(valid_o == 1'b0, "R7 no strobe after abort", 64'(valid_o), 64'd0);

    first_at = '{63, 62, -1, 0, 2, -1, 40, 7};
    conversion(2'b00, 1'b0);
    idle_phase(2'b00, 5, 1'b0);

    check(popped == pushed, "R5 one strobe per conversion", 64'(popped), 64'(pushed));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule